// File: doc/BRIEF.md
# Compare timer with auto-increment

This block is one timer frame that sits beside a free-running 64-bit system count. It does not count by itself. It watches the count it is given and shows it to software through a 32-bit register port. It raises an interrupt when the count reaches a programmed 64-bit target. Software can set that target directly as two halves. It can also set it through a signed 32-bit timer-value view, which is relative to the current count.

The block also has an auto-increment mode. In this mode a second 64-bit target is loaded with the current count plus a reload interval. Each time the count reaches that target, the target moves forward by one interval and a sticky event bit is set. The event bit stays set until software writes the auto-increment control register with the event bit at 0. In this mode the status flag follows the sticky bit instead of the level comparison.

Register writes take effect on the rising clock edge when `wr_i` is high. Reads are combinational from `addr_i`.

Top module: `tmr_top`

## Requirements
- R1: After reset, these registers all read 0: control (0x2C), compare value (0x20 low, 0x24 high), auto-increment control (0x4C), reload interval (0x48) and auto-increment value (0x40 low, 0x44 high).
- R2: Offset 0x00 reads the low half of `cnt_i` and 0x04 reads the high half. Offset 0x10 reads the fixed FREQ_HZ parameter, which defaults to 32000000.
- R3: Control bit 0 is the enable and bit 1 is the mask, and both are writable. Bit 2 is a read-only status flag; writes to it are ignored. The status flag is 0 while the enable is 0. With auto-increment off, the status flag is 1 exactly when enable is 1 and `cnt_i` is at or above the compare value.
- R4: Reading offset 0x28 returns the compare value low half minus the low half of `cnt_i`, modulo 2^32. Writing 0x28 sets the compare value to `cnt_i` plus the sign-extended written word.
- R5: The compare value is written as two independent 32-bit halves, at 0x20 (low) and 0x24 (high).
- R6: Writing 0x4C with bit 0 at 1 while auto-increment is off loads the auto-increment value with `cnt_i` plus the zero-extended reload interval. Writing bit 0 at 1 while the mode is already on leaves the value unchanged.
- R7: While auto-increment is on and `cnt_i` is at or above the auto-increment value, the next clock edge adds the reload interval to the value and sets bit 1 (event) of 0x4C.
- R8: With auto-increment on, the status flag is enable AND the event bit. The event bit is cleared only by a write to 0x4C with bit 1 at 0. If a match happens in the same cycle as such a write, the match wins.
- R9: `irq_o` is high exactly when enable is 1, mask is 0 and the status flag is 1, with no clock delay.
- R10: Unmapped offsets read 0 and ignore writes. The count, frequency and auto-increment value offsets are read-only; writes to them are ignored.
- R11: All 64-bit sums (compare from the timer-value write, auto-increment load and auto-increment step) carry from the low half into the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 64 | System count value |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` |
| irq_o | output | 1 | Timer interrupt |

## Verification
Most internal state is visible at the ports in the same cycle. The enable, mask and target values can be read back at once, and a stale or miscarried target changes the timer-value readback and `irq_o` as soon as the count crosses it. An auto-increment step that is missed or doubled does not show until the next read of 0x40/0x44 or the next match. For that reason, the reference model compares the readback of whatever address is presented, and `irq_o`, on every clock. An event bit that is dropped or held wrongly shows in control bit 2 one edge after the match or after the clearing write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFF_CNT_LO  = 'h00;
  localparam int OFF_CNT_HI  = 'h04;
  localparam int OFF_FREQ    = 'h10;
  localparam int OFF_CMP_LO  = 'h20;
  localparam int OFF_CMP_HI  = 'h24;
  localparam int OFF_TVAL    = 'h28;
  localparam int OFF_CTL     = 'h2C;
  localparam int OFF_AIV_LO  = 'h40;
  localparam int OFF_AIV_HI  = 'h44;
  localparam int OFF_RELOAD  = 'h48;
  localparam int OFF_AI_CTL  = 'h4C;

  localparam int CTL_EN   = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_STAT = 2;
  localparam int AI_EN    = 0;
  localparam int AI_EVT   = 1;

  typedef struct packed {
    logic cmp_lo;
    logic cmp_hi;
    logic tval;
    logic ctl;
    logic reload;
    logic ai_ctl;
  } wr_strb_t;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_strb_t          strb_o
);
  always_comb begin
    strb_o        = '0;
    strb_o.cmp_lo = wr_i && (addr_i == ADDR_W'(OFF_CMP_LO));
    strb_o.cmp_hi = wr_i && (addr_i == ADDR_W'(OFF_CMP_HI));
    strb_o.tval   = wr_i && (addr_i == ADDR_W'(OFF_TVAL));
    strb_o.ctl    = wr_i && (addr_i == ADDR_W'(OFF_CTL));
    strb_o.reload = wr_i && (addr_i == ADDR_W'(OFF_RELOAD));
    strb_o.ai_ctl = wr_i && (addr_i == ADDR_W'(OFF_AI_CTL));
  end
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp
  import tmr_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int CNT_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  wr_strb_t          strb_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output logic              mask_o,
  output logic [CNT_W-1:0]  cval_o,
  output logic              hit_o,
  output logic [DATA_W-1:0] tval_o
);
  logic [1:0][DATA_W-1:0] cval_q;
  logic [CNT_W-1:0]       rel_sum;
  logic [1:0]             half_we;

  assign rel_sum = cnt_i + {{DATA_W{wdata_i[DATA_W-1]}}, wdata_i};
  assign half_we = {strb_i.cmp_hi, strb_i.cmp_lo};

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cval_q[h] <= '0;
      else if (strb_i.tval)   cval_q[h] <= rel_sum[h*DATA_W +: DATA_W];
      else if (half_we[h])    cval_q[h] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      mask_o <= 1'b0;
    end else if (strb_i.ctl) begin
      en_o   <= wdata_i[CTL_EN];
      mask_o <= wdata_i[CTL_MASK];
    end
  end

  assign cval_o = cval_q;
  assign hit_o  = cnt_i >= cval_o;
  assign tval_o = cval_q[0] - cnt_i[DATA_W-1:0];
endmodule

// File: rtl/tmr_ainc.sv
module tmr_ainc
  import tmr_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int CNT_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  wr_strb_t          strb_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ai_en_o,
  output logic              evt_o,
  output logic [CNT_W-1:0]  aival_o,
  output logic [DATA_W-1:0] reload_o
);
  logic [CNT_W-1:0] reload_ext;
  logic             match;

  assign reload_ext = {{DATA_W{1'b0}}, reload_o};
  assign match      = ai_en_o && (cnt_i >= aival_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ai_en_o  <= 1'b0;
      evt_o    <= 1'b0;
      aival_o  <= '0;
      reload_o <= '0;
    end else begin
      if (strb_i.reload) reload_o <= wdata_i;
      if (strb_i.ai_ctl) begin
        ai_en_o <= wdata_i[AI_EN];
        evt_o   <= wdata_i[AI_EVT];
        // load only on the off->on transition
        if (wdata_i[AI_EN] && !ai_en_o) aival_o <= cnt_i + reload_ext;
      end
      // a match overrides a same-cycle clearing write
      if (match) begin
        aival_o <= aival_o + reload_ext;
        evt_o   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter  int          DATA_W  = 32,
  parameter  int          ADDR_W  = 8,
  parameter  int unsigned FREQ_HZ = 32'd32000000,
  localparam int          CNT_W   = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  wr_strb_t          strb;
  logic              en, mask, hit, ai_en, evt, status;
  logic [CNT_W-1:0]  cval, aival;
  logic [DATA_W-1:0] tval, reload;

  tmr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .strb_o (strb)
  );

  tmr_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt_i),
    .strb_i  (strb),
    .wdata_i (wdata_i),
    .en_o    (en),
    .mask_o  (mask),
    .cval_o  (cval),
    .hit_o   (hit),
    .tval_o  (tval)
  );

  tmr_ainc #(.DATA_W(DATA_W)) u_ainc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt_i),
    .strb_i   (strb),
    .wdata_i  (wdata_i),
    .ai_en_o  (ai_en),
    .evt_o    (evt),
    .aival_o  (aival),
    .reload_o (reload)
  );

  assign status = en && (ai_en ? evt : hit);
  assign irq_o  = status && !mask;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFF_CNT_LO): rdata_o = cnt_i[DATA_W-1:0];
      ADDR_W'(OFF_CNT_HI): rdata_o = cnt_i[CNT_W-1:DATA_W];
      ADDR_W'(OFF_FREQ):   rdata_o = DATA_W'(FREQ_HZ);
      ADDR_W'(OFF_CMP_LO): rdata_o = cval[DATA_W-1:0];
      ADDR_W'(OFF_CMP_HI): rdata_o = cval[CNT_W-1:DATA_W];
      ADDR_W'(OFF_TVAL):   rdata_o = tval;
      ADDR_W'(OFF_CTL): begin
        rdata_o[CTL_EN]   = en;
        rdata_o[CTL_MASK] = mask;
        rdata_o[CTL_STAT] = status;
      end
      ADDR_W'(OFF_AIV_LO): rdata_o = aival[DATA_W-1:0];
      ADDR_W'(OFF_AIV_HI): rdata_o = aival[CNT_W-1:DATA_W];
      ADDR_W'(OFF_RELOAD): rdata_o = reload;
      ADDR_W'(OFF_AI_CTL): begin
        rdata_o[AI_EN]  = ai_en;
        rdata_o[AI_EVT] = evt;
      end
      default:             rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int CNT_W  = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [DATA_W-1:0] wdata_i,
  input wr_strb_t          strb,
  input logic              en,
  input logic              mask,
  input logic              ai_en,
  input logic              evt,
  input logic [CNT_W-1:0]  cval,
  input logic [CNT_W-1:0]  aival,
  input logic [DATA_W-1:0] reload,
  input logic              irq_o
);
  logic ai_hit;
  assign ai_hit = ai_en && (cnt_i >= aival);

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en && !mask)); // R9

  AST_CMP_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !mask && !ai_en && cnt_i >= cval) |-> irq_o); // R3

  AST_TVAL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb.tval |=> cval == $past(cnt_i) + {{DATA_W{$past(wdata_i[DATA_W-1])}}, $past(wdata_i)}); // R4

  AST_AI_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb.ai_ctl && wdata_i[AI_EN] && !ai_en) |=> aival == $past(cnt_i) + {{DATA_W{1'b0}}, $past(reload)}); // R6

  AST_AI_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ai_hit |=> (aival == $past(aival) + {{DATA_W{1'b0}}, $past(reload)}) && evt); // R7

  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && !strb.ai_ctl) |=> evt); // R8
endmodule

bind tmr_top tmr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt_i   (cnt_i),
  .wdata_i (wdata_i),
  .strb    (strb),
  .en      (en),
  .mask    (mask),
  .ai_en   (ai_en),
  .evt     (evt),
  .cval    (cval),
  .aival   (aival),
  .reload  (reload),
  .irq_o   (irq_o)
);

// File: tb/sim_tmr_top.sv
module sim_tmr_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [63:0] cnt_i;
  logic        wr_i;
  logic [7:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  // reference model state
  logic        m_en, m_mask, m_ai_en, m_evt;
  logic [63:0] m_cval, m_aival;
  logic [31:0] m_reload;

  always #(CLK_P/2) clk = ~clk;

  tmr_top u0 (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  function automatic logic m_status();
    return m_en && (m_ai_en ? m_evt : (cnt_i >= m_cval));
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return cnt_i[31:0];
      8'h04: return cnt_i[63:32];
      8'h10: return 32'd32000000;
      8'h20: return m_cval[31:0];
      8'h24: return m_cval[63:32];
      8'h28: return m_cval[31:0] - cnt_i[31:0];
      8'h2C: return {29'd0, m_status(), m_mask, m_en};
      8'h40: return m_aival[31:0];
      8'h44: return m_aival[63:32];
      8'h48: return m_reload;
      8'h4C: return {30'd0, m_evt, m_ai_en};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h10: return "R2";
      8'h20, 8'h24:        return "R5";
      8'h28:               return "R4";
      8'h2C:               return "R3";
      8'h40, 8'h44:        return "R7";
      8'h48:               return "R6";
      8'h4C:               return "R8";
      default:             return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // model update on each edge
  always @(posedge clk) begin
    logic        hit;
    logic [31:0] old_rl;
    if (!rst_ni) begin
      m_en = 0; m_mask = 0; m_ai_en = 0; m_evt = 0;
      m_cval = 0; m_aival = 0; m_reload = 0;
    end else begin
      hit    = m_ai_en && (cnt_i >= m_aival);
      old_rl = m_reload;
      if (wr_i) begin
        case (addr_i)
          8'h20: m_cval[31:0]  = wdata_i;
          8'h24: m_cval[63:32] = wdata_i;
          8'h28: m_cval = cnt_i + {{32{wdata_i[31]}}, wdata_i};
          8'h2C: begin m_en = wdata_i[0]; m_mask = wdata_i[1]; end
          8'h48: m_reload = wdata_i;
          8'h4C: begin
            if (wdata_i[0] && !m_ai_en) m_aival = cnt_i + {32'd0, old_rl};
            m_ai_en = wdata_i[0];
            m_evt   = wdata_i[1];
          end
          default: ;
        endcase
      end
      if (hit) begin
        m_aival = m_aival + {32'd0, old_rl};
        m_evt   = 1'b1;
      end
    end
  end

  // per-cycle comparison, away from both edges
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/2 - 1);
      if (rst_ni === 1'b1) begin
        chk(tag_of(addr_i), rdata_o, m_read(addr_i));
        chk("R9", {31'd0, irq_o}, {31'd0, m_status() && !m_mask});
      end
    end
  end

  task automatic do_wr(logic [7:0] a, logic [31:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    addr_i = a;
    #1;
    chk(tag, rdata_o, exp);
    @(negedge clk);
  endtask

  task automatic irq_is(logic exp, string tag);
    #1;
    chk(tag, {31'd0, irq_o}, {31'd0, exp});
    @(negedge clk);
  endtask

  task automatic adv(int n);
    for (int i = 0; i < n; i++) begin
      cnt_i = cnt_i + 64'd1;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; cnt_i = '0; wr_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset values
    rd(8'h2C, 32'd0, "R1");
    rd(8'h20, 32'd0, "R1");
    rd(8'h24, 32'd0, "R1");
    rd(8'h4C, 32'd0, "R1");
    rd(8'h48, 32'd0, "R1");
    rd(8'h40, 32'd0, "R1");
    rd(8'h00, 32'd0, "R2");
    rd(8'h10, 32'd32000000, "R2");

    do_wr(8'h2C, 32'd1);
    adv(100);
    rd(8'h00, 32'd100, "R2");
    rd(8'h04, 32'd0, "R2");

    // R5 compare halves, R4 timer-value view
    do_wr(8'h20, 32'd4000);
    do_wr(8'h24, 32'd0);
    rd(8'h28, 32'd3900, "R4");
    rd(8'h2C, 32'd1, "R3");
    adv(3899);
    rd(8'h2C, 32'd1, "R3");
    irq_is(1'b0, "R9");
    adv(1);
    rd(8'h28, 32'd0, "R4");
    rd(8'h2C, 32'd5, "R3");
    irq_is(1'b1, "R9");
    do_wr(8'h2C, 32'd7);           // mask on, status bit write ignored
    rd(8'h2C, 32'd7, "R3");
    irq_is(1'b0, "R9");
    do_wr(8'h2C, 32'd4);           // disabled: status must drop
    rd(8'h2C, 32'd0, "R3");
    do_wr(8'h2C, 32'd1);

    // R6 auto-increment enable
    do_wr(8'h48, 32'd200);
    do_wr(8'h4C, 32'd1);
    rd(8'h40, 32'd4200, "R6");
    rd(8'h44, 32'd0, "R6");
    rd(8'h2C, 32'd1, "R8");
    adv(100);
    rd(8'h2C, 32'd1, "R7");
    adv(100);
    rd(8'h2C, 32'd5, "R7");
    rd(8'h40, 32'd4400, "R7");
    rd(8'h4C, 32'd3, "R7");
    adv(100);
    rd(8'h2C, 32'd5, "R8");        // sticky past the match
    do_wr(8'h4C, 32'd1);
    rd(8'h2C, 32'd1, "R8");
    rd(8'h40, 32'd4400, "R6");     // no reload while already on
    adv(100);
    rd(8'h2C, 32'd5, "R7");
    rd(8'h40, 32'd4600, "R7");

    // R10 read-only and unmapped
    do_wr(8'h40, 32'h1234);
    rd(8'h40, 32'd4600, "R10");
    do_wr(8'h00, 32'h5555);
    rd(8'h00, 32'd4400, "R10");
    do_wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, 32'd0, "R10");

    // R11 high-word carry
    do_wr(8'h4C, 32'd0);
    cnt_i = 64'h42_0000_0000 + 64'd4400;
    @(negedge clk);
    rd(8'h00, 32'd4400, "R11");
    rd(8'h04, 32'h42, "R11");
    do_wr(8'h4C, 32'd1);
    rd(8'h40, 32'd4600, "R11");
    rd(8'h44, 32'h42, "R11");
    do_wr(8'h4C, 32'd0);
    do_wr(8'h48, 32'h200);
    cnt_i = 64'h1_FFFF_FF80;
    @(negedge clk);
    do_wr(8'h4C, 32'd1);
    rd(8'h40, 32'h180, "R11");
    rd(8'h44, 32'h2, "R11");

    // R4 signed timer-value write with borrow
    do_wr(8'h4C, 32'd0);
    cnt_i = 64'h5_0000_0010;
    @(negedge clk);
    do_wr(8'h28, 32'hFFFF_FFE0);
    rd(8'h20, 32'hFFFF_FFF0, "R4");
    rd(8'h24, 32'h4, "R4");
    rd(8'h2C, 32'd5, "R3");
    rd(8'h28, 32'hFFFF_FFE0, "R4");

    // R8 match beats a same-cycle clearing write
    do_wr(8'h4C, 32'd1);
    rd(8'h40, 32'h210, "R6");
    cnt_i = 64'h5_0000_0210;
    do_wr(8'h4C, 32'd1);
    rd(8'h2C, 32'd5, "R8");
    rd(8'h40, 32'h410, "R7");
    do_wr(8'h4C, 32'd1);
    rd(8'h2C, 32'd1, "R8");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule